// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block runs Clause 22 management frames on an MDIO bus on behalf of software. Software sees three 32-bit registers through a plain register port: a status word with a busy flag, a command word, and a read-result word. One write to the command word carries the operation, the PHY address, the register address and the write data, and starts a complete frame. The block then drives the management clock and the bidirectional data pin through an output, an output enable and an input.

Software polls busy until it reads 0, writes a command, and, for a read, polls busy again before it fetches the result. A read on which no PHY drives the bus during turnaround is reported through a two-bit error field next to the 16-bit result. Commands are not queued. The register port is control traffic and has no back-pressure: a write is taken in the cycle `csr_wr` is high. A command write that cannot start a frame is dropped without a trace. Reads of the port are combinational.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status word (offset 0x0) and the read-result word (offset 0xC) read 0, `mdc` is low and `mdio_oe` is low.
- R2: A write to offset 0x8 whose bit 31 is 1 and in which exactly one of bit 1 (write) and bit 2 (read) is 1 starts a frame. Status bit 3 (busy) reads 1 from the cycle after that write.
- R3: A command that does not meet R2 starts no frame and leaves busy at 0 and `mdio_oe` low. This covers bit 31 clear, both opcode bits set, neither opcode bit set, and a command pattern written to an offset other than 0x8.
- R4: A command write made while busy is 1 is ignored. The frame in progress completes unchanged and no further frame follows.
- R5: Each frame is 64 bits sent MSB first: 32 ones, start bits 01, opcode 01 for a write or 10 for a read, PHY address from command bits 29:25, register address from bits 24:20, two turnaround bits, then 16 data bits. On a write the turnaround is 10 and the data comes from command bits 19:4.
- R6: While busy, `mdc` has a period of 2×MDC_HALF_CYCLES clocks. It stays low while idle, and `mdio_o` and `mdio_oe` change only where `mdc` falls.
- R7: On a read, `mdio_oe` goes low for the turnaround and data bits. The data bits are sampled as `mdc` rises and appear in bits 15:0 at offset 0xC, and bits 17:16 read 00 when the second turnaround bit was sampled as 0.
- R8: When the second turnaround bit of a read is sampled as 1 (no PHY answered), bits 17:16 at offset 0xC read 11.
- R9: Busy stays 1 for exactly 130×MDC_HALF_CYCLES clocks per frame: the 64 bit periods and one further idle MDC period.
- R10: A write frame leaves the read-result word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 4 | Byte offset of the register accessed |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (pad value) |

## Verification
The hardest case to reach is a command that arrives while a frame is already running. The register port accepts it at the protocol level, so nothing at the edge shows that it was dropped. The bench writes a second, valid command in the middle of a running frame. It then checks that the frame on the pins matches only the first command, that busy drops after the single-frame time, and that the pin monitor sees no extra frame in a long quiet window afterwards. A bus model drives turnaround and data only when a PHY is present; otherwise the pull-up level reaches the master, which produces the no-answer error.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;

  localparam logic [3:0] OFF_STATUS = 4'h0;
  localparam logic [3:0] OFF_CMD    = 4'h8;
  localparam logic [3:0] OFF_RESULT = 4'hC;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_GAP
  } eng_state_t;

  typedef struct packed {
    logic        valid;
    logic        rsv_hi;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
    logic        rsv_mid;
    logic        op_rd;
    logic        op_wr;
    logic        rsv_lo;
  } cmd_word_t;

  typedef struct packed {
    logic        is_read;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int MDC_HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int CW = (MDC_HALF_CYCLES > 1) ? $clog2(MDC_HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_csr_port.sv
module mdio_csr_port
  import mdio_mgmt_pkg::*;
(
  input  logic        csr_wr,
  input  logic [3:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  input  logic        busy,
  input  logic [15:0] rd_data,
  input  logic [1:0]  rd_err,
  output logic        start,
  output mgmt_cmd_t   cmd,
  output logic [31:0] csr_rdata
);

  cmd_word_t w;
  logic      op_ok;
  logic      unused_rsv_bits;

  assign w               = cmd_word_t'(csr_wdata);
  assign unused_rsv_bits = ^{w.rsv_hi, w.rsv_mid, w.rsv_lo};
  assign op_ok           = w.op_rd ^ w.op_wr;
  assign start           = csr_wr && (csr_addr == OFF_CMD) && w.valid && op_ok && !busy;

  assign cmd.is_read = w.op_rd;
  assign cmd.phy     = w.phy;
  assign cmd.regad   = w.regad;
  assign cmd.wdata   = w.wdata;

  always_comb begin
    case (csr_addr)
      OFF_STATUS: csr_rdata = {28'd0, busy, 3'd0};
      OFF_RESULT: csr_rdata = {14'd0, rd_err, rd_data};
      default:    csr_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data,
  output logic [1:0]  rd_err
);

  eng_state_t             state;
  logic [IDX_W-1:0]       bit_idx;
  logic [FRAME_BITS-1:0]  shreg;
  logic [FRAME_BITS-1:0]  frame;
  logic                   is_rd;
  logic                   ta_bad;
  logic [15:0]            rd_sh;
  logic                   last_bit;
  logic                   next_released;

  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(TA_SECOND);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_FIRST);
  localparam logic [IDX_W-1:0] IDX_PRETA = IDX_W'(TA_FIRST - 1);

  // Frame image, sent from bit 63 down.
  assign frame = {32'hFFFF_FFFF, 2'b01,
                  cmd.is_read ? 2'b10 : 2'b01,
                  cmd.phy, cmd.regad,
                  cmd.is_read ? 2'b11 : 2'b10,
                  cmd.is_read ? 16'hFFFF : cmd.wdata};

  assign busy          = (state != ENG_IDLE);
  assign mdio_o        = shreg[FRAME_BITS-1];
  assign last_bit      = (bit_idx == IDX_LAST);
  assign next_released = is_rd && (bit_idx >= IDX_PRETA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      ta_bad  <= 1'b0;
      rd_sh   <= '0;
      rd_data <= '0;
      rd_err  <= '0;
      mdio_oe <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            state   <= ENG_SHIFT;
            shreg   <= frame;
            bit_idx <= '0;
            is_rd   <= cmd.is_read;
            ta_bad  <= 1'b0;
            mdio_oe <= 1'b1;
          end
        end
        ENG_SHIFT: begin
          if (rise_evt && is_rd) begin
            if (bit_idx == IDX_TA2) begin
              ta_bad <= mdio_i;
            end else if (bit_idx >= IDX_DATA) begin
              rd_sh <= {rd_sh[14:0], mdio_i};
            end
          end
          if (fall_evt) begin
            if (last_bit) begin
              state   <= ENG_GAP;
              mdio_oe <= 1'b0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
              mdio_oe <= !next_released;
            end
          end
        end
        ENG_GAP: begin
          if (fall_evt) begin
            state <= ENG_IDLE;
            if (is_rd) begin
              rd_data <= rd_sh;
              rd_err  <= {2{ta_bad}};
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [3:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic        busy;
  logic        start;
  mgmt_cmd_t   cmd;
  logic        rise_evt;
  logic        fall_evt;
  logic [15:0] rd_data;
  logic [1:0]  rd_err;

  mdio_csr_port u_port (
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .busy      (busy),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .start     (start),
    .cmd       (cmd),
    .csr_rdata (csr_rdata)
  );

  mdio_mdc_gen #(.MDC_HALF_CYCLES(MDC_HALF_CYCLES)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data),
    .rd_err   (rd_err)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int MDC_HALF_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_wr,
  input logic [3:0]  csr_addr,
  input logic [31:0] csr_wdata,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [1:0]  rd_err
);

  localparam int FRAME_CYC = 130 * MDC_HALF_CYCLES;
  localparam int CNT_W     = $clog2(FRAME_CYC + 2);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R2: a well-formed command on an idle block raises busy next cycle
  assert_busy_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !busy && csr_addr == 4'h8 && csr_wdata[31] && (csr_wdata[1] != csr_wdata[2]))
      |=> busy);

  // R3: a command with the valid bit clear leaves the block idle
  assert_invalid_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !busy && !csr_wdata[31]) |=> !busy);

  // R3: the data pin is never driven while idle
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R6: the clock rests low when idle
  assert_mdc_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R6: data changes only at a falling clock edge within a frame
  assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  // R7: output enable changes only at a falling clock edge within a frame
  assert_oe_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_oe)) |-> $fell(mdc));

  // R8: the error field is either clear or fully set
  assert_err_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err == 2'b00) || (rd_err == 2'b11));

  // R9: each busy period lasts exactly one frame time
  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CNT_W'(FRAME_CYC)));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.MDC_HALF_CYCLES(MDC_HALF_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_wr    (csr_wr),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata),
  .busy      (busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .rd_err    (rd_err)
);

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;

  localparam int HALF      = 4;
  localparam int FRAME_CYC = 130 * HALF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_wr;
  logic [3:0]  csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b0;
  logic        phy_present = 1'b0;
  logic [15:0] phy_data = 16'h0;

  int checks = 0;
  int fails = 0;
  int frames_seen = 0;
  int frames_sent = 0;
  logic done = 1'b0;

  typedef struct {
    logic        is_rd;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] wd;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  // Pull-up on the shared line; the PHY model drives only when enabled.
  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_mgmt_master #(.MDC_HALF_CYCLES(HALF)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_addr = 4'h0; csr_wdata = 32'h0;
    #1;
  endtask

  task automatic csr_read(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    csr_addr = a;
    #1;
    v = csr_rdata;
    csr_addr = 4'h0;
    #1;
  endtask

  function automatic logic [31:0] pack(input logic rd, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] wd);
    return {1'b1, 1'b0, phy, ra, wd, 1'b0, rd, !rd, 1'b0};
  endfunction

  // Driver: queue the expected frame, write the command, then time busy.
  task automatic issue(input logic rd, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd);
    exp_t e;
    int n;
    e.is_rd = rd; e.phy = phy; e.ra = ra; e.wd = wd;
    expq.push_back(e);
    frames_sent++;
    csr_write(4'h8, pack(rd, phy, ra, wd));
    chk("R2 busy after command", 64'(csr_rdata[3]), 64'd1);
    n = 0;
    while (csr_rdata[3] && n < 20000) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R9 busy length", 64'(n), 64'(FRAME_CYC));
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (csr_rdata[3] && n < 20000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  // Monitor and PHY model: decode each frame on the pins, answer reads,
  // pop the expected item and compare.
  initial begin
    logic [63:0] fr;
    logic        rd;
    longint      t0, t1;
    exp_t        e;
    forever begin
      wait (mdio_oe === 1'b1);
      fr = '0; rd = 1'b0; t0 = 0; t1 = 0;
      for (int i = 0; i < 64; i++) begin
        @(posedge mdc);
        if (i == 0) t0 = longint'($time);
        if (i == 1) t1 = longint'($time);
        fr = {fr[62:0], mdio_i};
        if (i == 35) rd = (fr[1:0] == 2'b10);
        @(negedge mdc);
        if (rd && phy_present && (i + 1) >= 47 && (i + 1) < 64) begin
          phy_en  = 1'b1;
          phy_bit = ((i + 1) == 47) ? 1'b0 : phy_data[63 - (i + 1)];
        end else begin
          phy_en = 1'b0;
        end
      end
      wait (mdio_oe === 1'b0);
      frames_seen++;
      if (expq.size() == 0) begin
        chk("R4 unexpected frame on pins", 64'(fr[29:18]), 64'h0);
      end else begin
        e = expq.pop_front();
        chk("R5 preamble", 64'(fr[63:32]), 64'hFFFF_FFFF);
        chk("R5 start/op/phy/reg", 64'(fr[31:18]),
            64'({2'b01, (e.is_rd ? 2'b10 : 2'b01), e.phy, e.ra}));
        if (!e.is_rd)
          chk("R5 write turnaround and data", 64'(fr[17:0]), 64'({2'b10, e.wd}));
        chk("R6 mdc period", 64'(t1 - t0), 64'(2 * HALF * 8));
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; csr_wr = 1'b0; csr_addr = 4'h0; csr_wdata = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    csr_read(4'h0, v); chk("R1 status after reset", 64'(v), 64'h0);
    csr_read(4'hC, v); chk("R1 result after reset", 64'(v), 64'h0);
    chk("R1 mdc low", 64'(mdc), 64'h0);
    chk("R1 oe low", 64'(mdio_oe), 64'h0);

    // R5/R9 write frames, several patterns
    issue(1'b0, 5'd1, 5'd0, 16'hA5C3);
    issue(1'b0, 5'd31, 5'd31, 16'hFFFF);
    issue(1'b0, 5'd0, 5'd17, 16'h0001);

    // R7 reads with a PHY answering
    phy_present = 1'b1; phy_data = 16'h1234;
    issue(1'b1, 5'd5, 5'd2, 16'h0);
    csr_read(4'hC, v); chk("R7 read data, no error", 64'(v), 64'h0000_1234);
    phy_data = 16'hBEEF;
    issue(1'b1, 5'd3, 5'd31, 16'h0);
    csr_read(4'hC, v); chk("R7 read data second pattern", 64'(v), 64'h0000_BEEF);

    // R10 a write leaves the result word alone
    issue(1'b0, 5'd9, 5'd4, 16'h5555);
    csr_read(4'hC, v); chk("R10 result kept after write", 64'(v), 64'h0000_BEEF);

    // R8 no PHY answers
    phy_present = 1'b0;
    issue(1'b1, 5'd20, 5'd7, 16'h0);
    csr_read(4'hC, v); chk("R8 error field on missing PHY", 64'(v), 64'h0003_FFFF);

    // R3 malformed commands and wrong offset
    csr_write(4'h8, pack(1'b0, 5'd1, 5'd1, 16'h1111) & 32'h7FFF_FFFF);
    chk("R3 valid clear keeps idle", 64'(csr_rdata[3]), 64'h0);
    csr_write(4'h8, pack(1'b0, 5'd1, 5'd1, 16'h1111) | 32'h0000_0006);
    chk("R3 both opcodes keep idle", 64'(csr_rdata[3]), 64'h0);
    csr_write(4'h8, pack(1'b0, 5'd1, 5'd1, 16'h1111) & 32'hFFFF_FFF9);
    chk("R3 no opcode keeps idle", 64'(csr_rdata[3]), 64'h0);
    csr_write(4'h0, pack(1'b0, 5'd1, 5'd1, 16'h1111));
    chk("R3 command at status offset keeps idle", 64'(csr_rdata[3]), 64'h0);
    repeat (50) @(negedge clk);
    chk("R3 pin not driven", 64'(mdio_oe), 64'h0);

    // R4 command during a running frame is dropped
    begin
      exp_t e;
      e.is_rd = 1'b0; e.phy = 5'd12; e.ra = 5'd6; e.wd = 16'h0F0F;
      expq.push_back(e);
      frames_sent++;
      csr_write(4'h8, pack(1'b0, 5'd12, 5'd6, 16'h0F0F));
      repeat (100) @(negedge clk);
      csr_write(4'h8, pack(1'b0, 5'd2, 5'd3, 16'hDEAD));
      chk("R4 still busy after late command", 64'(csr_rdata[3]), 64'd1);
      wait_idle();
      repeat (600) @(negedge clk);
      chk("R4 no second frame", 64'(frames_seen), 64'(frames_sent));
      chk("R4 block idle", 64'(csr_rdata[3]), 64'h0);
    end

    chk("R5 all queued frames seen", 64'(expq.size()), 64'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule